// File: doc/BRIEF.md
# Single-Bit Operation Execution Unit

This unit carries out the single-bit instruction class of a small 32-bit RISC core. An instruction arrives as a 16-bit first halfword together with a 16-bit extension halfword, qualified by a one-cycle `start` strobe. The unit reads one general register through an asynchronous read port. It drives a byte-wide memory port and owns the one-bit T condition flag.

Register forms change or test one bit in the low byte of a register and complete in the cycle they are issued. Memory forms run over three cycles:

- The first cycle forms a byte address from a base register and a displacement.
- The second cycle reads the byte.
- The third cycle either writes the byte back with one bit altered, or folds the bit into T using a load, AND or OR, optionally on the inverted bit.

An extension selector outside the nine defined codes is reported on `illegal` and has no other effect.

Top module: `bitop_unit`

## Requirements
- R1: A memory form is recognised when the first halfword matches 0011nnnn0iii1001. Bits [11:8] name the base register and bits [6:4] the bit index. In the extension halfword, bits [15:12] are the operation selector and bits [11:0] the displacement.
- R2: The memory byte address is the base register value plus the zero-extended, unscaled 12-bit displacement, wrapping modulo 2^32.
- R3: A memory form takes exactly three cycles. In the start cycle `busy` is high. In the second cycle `mem_rd_en` and `busy` are high. In the third cycle `done` is high, `busy` is low and `mem_rd_en` is low.
- R4: The write selectors each write the read byte back in the third cycle, with only bit iii altered, and leave T unchanged:
  - 0000 clears the bit.
  - 0001 sets the bit.
  - 0010 copies T into the bit.
- R5: The flag selectors perform no memory write and update T at the clock edge that ends the third cycle:
  - 0011 loads the bit into T.
  - 1011 loads the inverted bit into T.
  - 0100 ANDs the bit into T.
  - 1100 ANDs the inverted bit into T.
  - 0101 ORs the bit into T.
  - 1101 ORs the inverted bit into T.
- R6: Register forms complete in one cycle, with `done` high in the start cycle. In each encoding nnnn is the register and iii is the bit index:
  - 10000110nnnn0iii clears the bit.
  - 10000110nnnn1iii sets the bit.
  - 10000111nnnn0iii copies T into the bit.
  - 10000111nnnn1iii loads the bit into T, with no register write.
- R7: A register-form write returns the read register value with only bit iii of the low byte altered.
- R8: A memory form with any other selector value raises `illegal` for the start cycle only. It raises no `busy` and no `done`, makes no memory or register write, and leaves T unchanged.
- R9: T resets to 0. After reset `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction valid for one cycle, only while idle |
| op_hw0 | input | 16 | First instruction halfword |
| op_hw1 | input | 16 | Extension halfword (memory forms) |
| reg_rd_idx | output | 4 | Register read select |
| reg_rd_data | input | 32 | Register read data, same cycle |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_idx | output | 4 | Register write select |
| reg_wr_data | output | 32 | Register write data |
| mem_addr | output | 32 | Byte address |
| mem_rd_en | output | 1 | Byte read strobe |
| mem_rd_data | input | 8 | Byte read data, same cycle |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_wr_data | output | 8 | Byte write data |
| t_flag | output | 1 | T condition flag |
| busy | output | 1 | Memory form in progress, low in the final cycle |
| done | output | 1 | Instruction completes this cycle |
| illegal | output | 1 | Undefined selector seen |

## Verification
The assertions rely on several properties of the inputs:

- `start` is raised only while the unit is idle.
- Both halfwords and the register read data are stable during the start cycle.
- The memory returns read data in the same cycle as `mem_rd_en`.

The stimulus issues each instruction only after the previous one has finished. It serves register reads from a bench-held register file and memory reads from a fixed address hash, so every returned value is known.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
   localparam int unsigned HW_W   = 16;
   localparam int unsigned SEL_W  = 4;
   localparam int unsigned BIDX_W = 3;
   localparam int unsigned DISP_W = 12;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [3:0] {
      OP_CLR  = 4'h0,
      OP_SET  = 4'h1,
      OP_STT  = 4'h2,
      OP_LDT  = 4'h3,
      OP_AND  = 4'h4,
      OP_OR   = 4'h5,
      OP_LDN  = 4'hB,
      OP_ANDN = 4'hC,
      OP_ORN  = 4'hD
   } bop_e;

   typedef struct packed {
      logic              mem_form;
      logic              reg_form;
      logic              bad_sel;
      bop_e              op;
      logic [SEL_W-1:0]  base;
      logic [BIDX_W-1:0] bidx;
      logic [DISP_W-1:0] disp;
   } bdec_t;

   function automatic logic op_writes(input bop_e op);
      return (op == OP_CLR) || (op == OP_SET) || (op == OP_STT);
   endfunction
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
   import bitop_pkg::*;
(
   input  logic [HW_W-1:0] hw0,
   input  logic [HW_W-1:0] hw1,
   output bdec_t           dec
);
   logic is_mem;
   logic is_reg;

   assign is_mem = (hw0[15:12] == 4'b0011) && !hw0[7] && (hw0[3:0] == 4'b1001);
   assign is_reg = (hw0[15:9] == 7'b1000011);

   always_comb begin
      dec          = '0;
      dec.mem_form = is_mem;
      dec.reg_form = is_reg;
      dec.op       = OP_CLR;
      if (is_mem) begin
         dec.base = hw0[11:8];
         dec.bidx = hw0[6:4];
         dec.disp = hw1[DISP_W-1:0];
         case (hw1[15:12])
            4'h0: dec.op = OP_CLR;
            4'h1: dec.op = OP_SET;
            4'h2: dec.op = OP_STT;
            4'h3: dec.op = OP_LDT;
            4'h4: dec.op = OP_AND;
            4'h5: dec.op = OP_OR;
            4'hB: dec.op = OP_LDN;
            4'hC: dec.op = OP_ANDN;
            4'hD: dec.op = OP_ORN;
            default: dec.bad_sel = 1'b1;
         endcase
      end else if (is_reg) begin
         dec.base = hw0[7:4];
         dec.bidx = hw0[2:0];
         case ({hw0[8], hw0[3]})
            2'b00:   dec.op = OP_CLR;
            2'b01:   dec.op = OP_SET;
            2'b10:   dec.op = OP_STT;
            default: dec.op = OP_LDT;
         endcase
      end
   end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
   import bitop_pkg::*;
(
   input  logic [BYTE_W-1:0] byte_in,
   input  logic [BIDX_W-1:0] bidx,
   input  bop_e              op,
   input  logic              t_in,
   output logic [BYTE_W-1:0] byte_out,
   output logic              t_out
);
   logic sel_bit;
   logic new_bit;

   assign sel_bit = byte_in[bidx];

   always_comb begin
      case (op)
         OP_CLR:  new_bit = 1'b0;
         OP_SET:  new_bit = 1'b1;
         default: new_bit = t_in;
      endcase
      case (op)
         OP_LDT:  t_out = sel_bit;
         OP_LDN:  t_out = !sel_bit;
         OP_AND:  t_out = sel_bit & t_in;
         OP_ANDN: t_out = !sel_bit & t_in;
         OP_OR:   t_out = sel_bit | t_in;
         OP_ORN:  t_out = !sel_bit | t_in;
         default: t_out = t_in;
      endcase
   end

   for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_bit
      assign byte_out[gi] = (bidx == gi[BIDX_W-1:0]) ? new_bit : byte_in[gi];
   end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
   import bitop_pkg::*;
#(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned NREGS = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [HW_W-1:0]          op_hw0,
   input  logic [HW_W-1:0]          op_hw1,
   output logic [$clog2(NREGS)-1:0] reg_rd_idx,
   input  logic [XLEN-1:0]          reg_rd_data,
   output logic                     reg_wr_en,
   output logic [$clog2(NREGS)-1:0] reg_wr_idx,
   output logic [XLEN-1:0]          reg_wr_data,
   output logic [XLEN-1:0]          mem_addr,
   output logic                     mem_rd_en,
   input  logic [BYTE_W-1:0]        mem_rd_data,
   output logic                     mem_wr_en,
   output logic [BYTE_W-1:0]        mem_wr_data,
   output logic                     t_flag,
   output logic                     busy,
   output logic                     done,
   output logic                     illegal
);
   localparam int unsigned RIDX_W = $clog2(NREGS);
   localparam int unsigned ZPAD   = XLEN - DISP_W;

   if (XLEN <= DISP_W || XLEN <= BYTE_W) begin : g_bad_xlen
      $error("bitop_unit: XLEN must exceed displacement and byte widths");
   end
   if (NREGS != (1 << SEL_W)) begin : g_bad_nregs
      $error("bitop_unit: NREGS must match the 4-bit register field");
   end
   if (BYTE_W != (1 << BIDX_W)) begin : g_bad_byte
      $error("bitop_unit: BYTE_W must match the 3-bit index");
   end

   typedef enum logic [1:0] {S_IDLE, S_READ, S_FIN} st_e;

   st_e               state;
   bdec_t             dec;
   logic [XLEN-1:0]   addr_q;
   logic [BYTE_W-1:0] data_q;
   bop_e              op_q;
   logic [BIDX_W-1:0] bidx_q;
   logic              t_q;
   logic              idle, in_fin, go_mem, go_reg;
   logic [BYTE_W-1:0] alu_in, alu_out;
   logic [BIDX_W-1:0] alu_bidx;
   bop_e              alu_op;
   logic              alu_t;

   bitop_decode u_dec (.hw0(op_hw0), .hw1(op_hw1), .dec(dec));

   assign idle    = (state == S_IDLE);
   assign in_fin  = (state == S_FIN);
   assign go_mem  = start && idle && dec.mem_form && !dec.bad_sel;
   assign go_reg  = start && idle && dec.reg_form;
   assign illegal = start && idle && dec.mem_form && dec.bad_sel;

   assign alu_in   = in_fin ? data_q : reg_rd_data[BYTE_W-1:0];
   assign alu_bidx = in_fin ? bidx_q : dec.bidx;
   assign alu_op   = in_fin ? op_q   : dec.op;

   bitop_alu u_alu (
      .byte_in (alu_in),
      .bidx    (alu_bidx),
      .op      (alu_op),
      .t_in    (t_q),
      .byte_out(alu_out),
      .t_out   (alu_t)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         addr_q <= '0;
         data_q <= '0;
         op_q   <= OP_CLR;
         bidx_q <= '0;
         t_q    <= 1'b0;
      end else begin
         case (state)
            S_IDLE: begin
               if (go_mem) begin
                  addr_q <= reg_rd_data + {{ZPAD{1'b0}}, dec.disp};
                  op_q   <= dec.op;
                  bidx_q <= dec.bidx;
                  state  <= S_READ;
               end else if (go_reg && !op_writes(dec.op)) begin
                  t_q <= alu_t;
               end
            end
            S_READ: begin
               data_q <= mem_rd_data;
               state  <= S_FIN;
            end
            default: begin
               if (!op_writes(op_q)) t_q <= alu_t;
               state <= S_IDLE;
            end
         endcase
      end
   end

   assign reg_rd_idx  = dec.base;
   assign reg_wr_idx  = dec.base;
   assign reg_wr_en   = go_reg && op_writes(dec.op);
   assign reg_wr_data = {reg_rd_data[XLEN-1:BYTE_W], alu_out};
   assign mem_addr    = idle ? '0 : addr_q;
   assign mem_rd_en   = (state == S_READ);
   assign mem_wr_en   = in_fin && op_writes(op_q);
   assign mem_wr_data = alu_out;
   assign t_flag      = t_q;
   assign busy        = go_mem || (state == S_READ);
   assign done        = go_reg || in_fin;

   AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R3
   AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> $past(mem_rd_en)); // R3
   AST_MEM_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> $onehot0(mem_wr_data ^ data_q)); // R4
   AST_WRITE_KEEPS_T: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |=> $stable(t_flag)); // R4
   AST_REG_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> $onehot0(reg_wr_data ^ reg_rd_data)); // R7
   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!busy && !done && !mem_wr_en && !reg_wr_en)); // R8
   AST_ILLEGAL_KEEPS_T: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> $stable(t_flag)); // R8
   AST_NO_READ_AND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en)); // R3
endmodule

// File: tb/bitop_unit_tb.sv
`timescale 1ns/100ps
module bitop_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] op_hw0 = '0;
   logic [15:0] op_hw1 = '0;
   logic [3:0]  reg_rd_idx, reg_wr_idx;
   logic [31:0] reg_rd_data, reg_wr_data, mem_addr;
   logic        reg_wr_en, mem_rd_en, mem_wr_en, t_flag, busy, done, illegal;
   logic [7:0]  mem_rd_data, mem_wr_data;
   logic [31:0] regs [16];
   logic        tm = 1'b0;
   int          n_vec = 0;
   int          n_bad = 0;
   bit          finished = 1'b0;

   always #2.5 clk = !clk;

   function automatic logic [7:0] mem_fn(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'hA5;
   endfunction

   assign mem_rd_data = mem_fn(mem_addr);
   assign reg_rd_data = regs[reg_rd_idx];

   bitop_unit dut_i (.*);

   function automatic bit sel_legal(input logic [3:0] s);
      return (s <= 4'h5) || (s == 4'hB) || (s == 4'hC) || (s == 4'hD);
   endfunction

   function automatic bit sel_writes(input logic [3:0] s);
      return s <= 4'h2;
   endfunction

   function automatic logic [7:0] exp_byte(input logic [7:0] b, input logic [2:0] i,
                                           input logic [3:0] s, input logic t);
      logic [7:0] r = b;
      r[i] = (s == 4'h0) ? 1'b0 : (s == 4'h1) ? 1'b1 : t;
      return r;
   endfunction

   function automatic logic exp_t(input logic [7:0] b, input logic [2:0] i,
                                  input logic [3:0] s, input logic t);
      case (s)
         4'h3: return b[i];
         4'hB: return !b[i];
         4'h4: return b[i] & t;
         4'hC: return !b[i] & t;
         4'h5: return b[i] | t;
         4'hD: return !b[i] | t;
         default: return t;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic mem_instr(input logic [3:0] n, input logic [2:0] b,
                            input logic [3:0] s, input logic [11:0] disp);
      logic [31:0] ea = regs[n] + {20'd0, disp};
      logic [7:0]  dat = mem_fn(ea);
      logic        t_next = sel_writes(s) ? tm : exp_t(dat, b, s, tm);
      @(negedge clk);
      start = 1'b1;
      op_hw0 = {4'b0011, n, 1'b0, b, 4'b1001};
      op_hw1 = {s, disp};
      #1;
      if (!sel_legal(s)) begin
         chk(illegal && !busy && !done && !mem_wr_en && !reg_wr_en, "R8 quiet",
             {busy, done, mem_wr_en, illegal}, 32'h1);
         @(negedge clk); start = 1'b0; #1;
         chk(!illegal && t_flag == tm && !busy, "R8 T kept", t_flag, tm);
         return;
      end
      chk(busy && !done && !illegal, "R3 cycle1", {busy, done, illegal}, 32'h4);
      @(negedge clk); start = 1'b0; #1;
      chk(mem_rd_en && busy && !mem_wr_en, "R3 cycle2", {mem_rd_en, busy, mem_wr_en}, 32'h6);
      chk(mem_addr == ea, "R2 address", mem_addr, ea);
      @(negedge clk); #1;
      chk(done && !busy && !mem_rd_en, "R3 cycle3", {done, busy, mem_rd_en}, 32'h4);
      if (sel_writes(s)) begin
         chk(mem_wr_en && mem_addr == ea && mem_wr_data == exp_byte(dat, b, s, tm),
             "R4 write byte", mem_wr_data, exp_byte(dat, b, s, tm));
      end else begin
         chk(!mem_wr_en, "R5 no write", mem_wr_en, 0);
      end
      @(negedge clk); #1;
      chk(t_flag == t_next && !done, sel_writes(s) ? "R4 T kept" : "R5 T update", t_flag, t_next);
      tm = t_next;
   endtask

   task automatic reg_instr(input logic [1:0] k, input logic [3:0] n, input logic [2:0] b);
      logic [31:0] rv = regs[n];
      logic        t_next = (k == 2'd3) ? rv[b] : tm;
      rv[b] = (k == 2'd0) ? 1'b0 : (k == 2'd1) ? 1'b1 : tm;
      @(negedge clk);
      start = 1'b1;
      op_hw0 = {7'b1000011, k[1], n, k[0], b};
      op_hw1 = $urandom;
      #1;
      chk(done && !busy && !illegal, "R6 one cycle", {done, busy, illegal}, 32'h4);
      if (k != 2'd3) begin
         chk(reg_wr_en && reg_wr_idx == n && reg_wr_data == rv, "R7 reg write", reg_wr_data, rv);
         regs[n] = rv;
      end else begin
         chk(!reg_wr_en, "R6 load no write", reg_wr_en, 0);
      end
      @(negedge clk); start = 1'b0; #1;
      chk(t_flag == t_next && !done, "R6 T", t_flag, t_next);
      tm = t_next;
   endtask

   initial begin
      int seed_use;
      seed_use = $urandom(32'd1971);
      for (int i = 0; i < 16; i++) regs[i] = $urandom;
      repeat (3) @(negedge clk);
      #1;
      chk(t_flag == 1'b0 && !busy && !done, "R9 reset", {t_flag, busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(t_flag == 1'b0 && !busy && !done && !illegal, "R9 after reset", {t_flag, busy, done}, 0);
      // Directed: R1 field positions, R2 wrap and zero displacement
      regs[4'd9] = 32'hFFFF_FF80;
      mem_instr(4'd9, 3'd7, 4'h1, 12'hFFF);
      regs[4'd2] = 32'd0;
      mem_instr(4'd2, 3'd0, 4'h3, 12'h000);
      mem_instr(4'd2, 3'd0, 4'hB, 12'h000);
      mem_instr(4'd15, 3'd5, 4'h2, 12'h800);
      mem_instr(4'd3, 3'd3, 4'hE, 12'h123);
      mem_instr(4'd3, 3'd3, 4'h6, 12'h123);
      reg_instr(2'd3, 4'd0, 3'd7);
      reg_instr(2'd2, 4'd1, 3'd0);
      for (int j = 0; j < 400; j++) begin
         if ($urandom_range(0, 2) == 0) begin
            reg_instr(2'($urandom_range(0, 3)), 4'($urandom), 3'($urandom));
         end else begin
            mem_instr(4'($urandom), 3'($urandom), 4'($urandom), 12'($urandom));
         end
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule